// File: doc/BRIEF.md
# Coherence Message Three-Lane Link Multiplexer

This block sits between a node's coherence engine and a single physical network link. Outgoing coherence messages are sorted by message kind onto one of three virtual lanes, and each lane has its own queue and its own credit counter. Each cycle a fixed-priority arbiter picks one lane that holds a message and has a credit. The chosen flit goes out on the link tagged with its lane number. Because each message class has its own lane, a class that cannot make progress never blocks another class. This separation is what keeps the coherence protocol free of deadlock without negative acknowledgments or retries.

Lane 0 carries first-level requests from processors to the home node. Lane 1 carries everything the home node emits: replies to the requester and requests forwarded to a third-party owner. Lane 2 carries owner-to-requester replies, which include invalidation acknowledgments. Each lane is a FIFO, so flits of one lane, lane 1 in particular, leave in the order they were accepted. On the receive side, incoming flits are steered by their lane tag into three separate receive queues that the node drains independently.

Top module: `coh_vc_link`

## Requirements
- R1: The message kind on `tx_kind` selects the lane: kind 0 (request to home) uses lane 0, kind 1 (home reply) and kind 2 (home forward) use lane 1, kind 3 (owner reply or invalidation acknowledgment) uses lane 2. A sent flit carries that lane number on `link_vc`.
- R2: `tx_ready` is high exactly when the queue of the lane selected by the present `tx_kind` is not full. A full queue on one lane does not lower `tx_ready` for kinds that map to another lane.
- R3: When several lanes are eligible in one cycle, lane 2 is sent first, then lane 1, then lane 0.
- R4: A lane with no credit sends nothing. In the same cycle another lane that has both a flit and a credit is sent.
- R5: Each lane starts with `CREDITS` credits after reset. Each flit sent uses one credit and each pulse on `credit_ret[i]` gives one back to lane i. A lane at zero credits stalls and resumes after a return.
- R6: Within one lane, flits leave the link in the order `tx_ready` accepted them.
- R7: A flit accepted at clock edge k, with its lane eligible and no higher-priority lane eligible, appears on the link outputs for exactly one cycle after edge k+1.
- R8: A flit arriving with `rx_link_valid` and lane tag 0, 1 or 2 is written to that lane's receive queue. `rx_valid[i]` and `rx_data[i*W +: W]` show the head of queue i, and `rx_pop[i]` advances it in arrival order.
- R9: An incoming flit with lane tag 3 is discarded and enters no receive queue.
- R10: After reset `link_valid` is 0, `rx_valid` is 0 and `tx_ready` is 1 for every kind.
- R11: At most one lane is granted the link in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | 1 | Outgoing message present |
| tx_kind | input | 2 | Message kind, mapped to a lane per R1 |
| tx_payload | input | W | Outgoing message body |
| tx_ready | output | 1 | Selected lane queue can accept |
| link_valid | output | 1 | Flit on the physical link this cycle |
| link_vc | output | 2 | Lane tag of the link flit |
| link_payload | output | W | Link flit body |
| credit_ret | input | 3 | One-cycle credit return pulse per lane |
| rx_link_valid | input | 1 | Incoming flit present |
| rx_link_vc | input | 2 | Lane tag of incoming flit |
| rx_link_payload | input | W | Incoming flit body |
| rx_valid | output | 3 | Receive queue non-empty, per lane |
| rx_data | output | 3*W | Receive queue heads, lane i at bits i*W +: W |
| rx_pop | input | 3 | Consume head of receive queue, per lane |

## Verification
The bench drains all credits and then releases all three lanes in one cycle. A design with the priority order reversed or missing would send lane 0 or lane 1 first. It parks a flit on a lane without credit while another lane gets a credit; a design that serializes the lanes would send nothing, or the wrong lane. It fills lane 1 and then checks that kind-0 traffic is still accepted and sent. A design that ties `tx_ready` to any full queue would stall there, and one that reorders lane 1 would fail the ordered drain that follows. On the receive side, a flit tagged 3 must vanish; a design that aliases the tag into lane 0 or lane 2 would leave data behind.

// File: rtl/coh_vc_pkg.sv
package coh_vc_pkg;
    localparam int NUM_VC = 3;
    localparam int VC_W   = 2;

    typedef enum logic [1:0] {
        KIND_REQ_HOME   = 2'd0,
        KIND_HOME_REPLY = 2'd1,
        KIND_HOME_FWD   = 2'd2,
        KIND_OWNER_RPL  = 2'd3
    } msg_kind_e;

    function automatic logic [VC_W-1:0] lane_of(input logic [1:0] kind);
        case (kind)
            KIND_REQ_HOME:   return 2'd0;
            KIND_HOME_REPLY,
            KIND_HOME_FWD:   return 2'd1;
            default:         return 2'd2;
        endcase
    endfunction
endpackage

// File: rtl/coh_vc_fifo.sv
module coh_vc_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wr;
        logic [AW-1:0]           rd;
        logic [AW:0]             cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic do_push, do_pop;

    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == FULL_CNT);
    assign dout  = st_q.mem[st_q.rd];

    always_comb begin
        st_d    = st_q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (do_push) begin
            st_d.mem[st_q.wr] = din;
            st_d.wr           = st_q.wr + AW'(1);
        end
        if (do_pop) begin
            st_d.rd = st_q.rd + AW'(1);
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + (AW+1)'(1);
            2'b01:   st_d.cnt = st_q.cnt - (AW+1)'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2 / R8: writers must respect the full flag (tx gating, rx credits)
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R6: count stays within depth
    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL_CNT);
endmodule

// File: rtl/coh_vc_credit.sv
module coh_vc_credit #(
    parameter int MAX = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ret,
    input  logic take,
    output logic avail
);
    localparam int CW = $clog2(MAX + 1);
    localparam logic [CW-1:0] MAX_CNT = CW'(MAX);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cred_st_t;

    cred_st_t st_d, st_q;

    assign avail = (st_q.cnt != '0);

    always_comb begin
        st_d = st_q;
        case ({ret, take})
            2'b10:   st_d.cnt = st_q.cnt + CW'(1);
            2'b01:   st_d.cnt = st_q.cnt - CW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.cnt <= MAX_CNT;
        else        st_q     <= st_d;
    end

    // R5: a flit is never sent on an empty credit counter
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> st_q.cnt != '0);
    // R5: returns never push the count above its initial value
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (ret && !take) |-> st_q.cnt != MAX_CNT);
endmodule

// File: rtl/coh_vc_arb.sv
module coh_vc_arb #(
    parameter int N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    // Highest index wins: the last matching iteration overrides
    always_comb begin
        grant = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/coh_vc_link.sv
module coh_vc_link #(
    parameter int W       = 16,
    parameter int DEPTH   = 4,
    parameter int CREDITS = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             tx_valid,
    input  logic [1:0]                       tx_kind,
    input  logic [W-1:0]                     tx_payload,
    output logic                             tx_ready,
    output logic                             link_valid,
    output logic [1:0]                       link_vc,
    output logic [W-1:0]                     link_payload,
    input  logic [2:0]                       credit_ret,
    input  logic                             rx_link_valid,
    input  logic [1:0]                       rx_link_vc,
    input  logic [W-1:0]                     rx_link_payload,
    output logic [2:0]                       rx_valid,
    output logic [3*W-1:0]                   rx_data,
    input  logic [2:0]                       rx_pop
);
    import coh_vc_pkg::*;

    typedef struct packed {
        logic            valid;
        logic [VC_W-1:0] vc;
        logic [W-1:0]    payload;
    } link_st_t;

    link_st_t lk_d, lk_q;

    logic [VC_W-1:0]   tx_lane;
    logic [NUM_VC-1:0] tx_push, tx_full, tx_empty, has_cred, eligible, grant;
    logic [NUM_VC:0]   full_pad;
    logic [W-1:0]      tx_head [NUM_VC];
    logic [NUM_VC-1:0] rx_push, rx_full, rx_empty;

    assign tx_lane  = lane_of(tx_kind);
    assign full_pad = {1'b1, tx_full};
    assign tx_ready = !full_pad[tx_lane];

    for (genvar g = 0; g < NUM_VC; g++) begin : g_lane
        assign tx_push[g]  = tx_valid && tx_ready && (tx_lane == VC_W'(g));
        assign eligible[g] = !tx_empty[g] && has_cred[g];

        coh_vc_fifo #(.W(W), .DEPTH(DEPTH)) u_txq (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (tx_push[g]),
            .din   (tx_payload),
            .pop   (grant[g]),
            .dout  (tx_head[g]),
            .empty (tx_empty[g]),
            .full  (tx_full[g])
        );

        coh_vc_credit #(.MAX(CREDITS)) u_cred (
            .clk   (clk),
            .rst_n (rst_n),
            .ret   (credit_ret[g]),
            .take  (grant[g]),
            .avail (has_cred[g])
        );

        assign rx_push[g] = rx_link_valid && (rx_link_vc == VC_W'(g));

        coh_vc_fifo #(.W(W), .DEPTH(DEPTH)) u_rxq (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (rx_push[g]),
            .din   (rx_link_payload),
            .pop   (rx_pop[g]),
            .dout  (rx_data[g*W +: W]),
            .empty (rx_empty[g]),
            .full  (rx_full[g])
        );

        assign rx_valid[g] = !rx_empty[g];
    end

    coh_vc_arb #(.N(NUM_VC)) u_arb (
        .req   (eligible),
        .grant (grant)
    );

    always_comb begin
        lk_d         = '0;
        lk_d.valid   = |grant;
        for (int i = 0; i < NUM_VC; i++) begin
            if (grant[i]) begin
                lk_d.vc      = VC_W'(i);
                lk_d.payload = tx_head[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lk_q <= '0;
        else        lk_q <= lk_d;
    end

    assign link_valid   = lk_q.valid;
    assign link_vc      = lk_q.vc;
    assign link_payload = lk_q.payload;

    // R11: one lane on the wire per cycle
    a_r11_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R4: granted lane has data and credit
    a_r4_grant_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~(~tx_empty & has_cred)) == '0);
    // R4: link is not left idle while some lane is eligible
    a_r4_no_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_empty[0] && has_cred[0]) |-> (grant != '0));
    // R3: lane 0 only wins when neither higher lane is eligible
    a_r3_priority: assert property (@(posedge clk) disable iff (!rst_n)
        grant[0] |-> !(!tx_empty[2] && has_cred[2]) && !(!tx_empty[1] && has_cred[1]));
    // R7: a grant shows up on the link in the next cycle
    a_r7_link_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |=> link_valid);
    // R9: tag 3 reaches no receive queue
    a_r9_drop_tag3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_link_valid && rx_link_vc == 2'd3) |-> rx_push == '0);
    // R2: an accepted message never lands in a full queue
    a_r2_ready_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push & tx_full) == '0);
endmodule

// File: tb/tb_coh_vc_link.sv
module tb_coh_vc_link;
    localparam int W = 16;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           tx_valid;
    logic [1:0]     tx_kind;
    logic [W-1:0]   tx_payload;
    logic           tx_ready;
    logic           link_valid;
    logic [1:0]     link_vc;
    logic [W-1:0]   link_payload;
    logic [2:0]     credit_ret;
    logic           rx_link_valid;
    logic [1:0]     rx_link_vc;
    logic [W-1:0]   rx_link_payload;
    logic [2:0]     rx_valid;
    logic [3*W-1:0] rx_data;
    logic [2:0]     rx_pop;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    coh_vc_link #(.W(W), .DEPTH(4), .CREDITS(2)) dut (
        .clk(clk), .rst_n(rst_n),
        .tx_valid(tx_valid), .tx_kind(tx_kind), .tx_payload(tx_payload), .tx_ready(tx_ready),
        .link_valid(link_valid), .link_vc(link_vc), .link_payload(link_payload),
        .credit_ret(credit_ret),
        .rx_link_valid(rx_link_valid), .rx_link_vc(rx_link_vc), .rx_link_payload(rx_link_payload),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_pop(rx_pop)
    );

    // vector: {kind, expected lane, payload}
    localparam logic [19:0] VEC [6] = '{
        {2'd0, 2'd0, 16'h1A00},
        {2'd1, 2'd1, 16'h1A01},
        {2'd2, 2'd1, 16'h1A02},
        {2'd3, 2'd2, 16'h1A03},
        {2'd1, 2'd1, 16'h1A04},
        {2'd0, 2'd0, 16'h1A05}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] kind, input logic [W-1:0] pl);
        @(negedge clk);
        tx_valid = 1'b1; tx_kind = kind; tx_payload = pl;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic give(input logic [2:0] lanes);
        credit_ret = lanes;
        @(negedge clk);
        credit_ret = 3'b000;
    endtask

    task automatic expect_flit(input string req, input logic [1:0] vc, input logic [W-1:0] pl);
        @(negedge clk);
        check(req, {31'd0, link_valid}, 32'd1);
        check(req, {30'd0, link_vc}, {30'd0, vc});
        check(req, {16'd0, link_payload}, {16'd0, pl});
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; tx_valid = 1'b0; tx_kind = 2'd0; tx_payload = '0;
        credit_ret = '0; rx_link_valid = 1'b0; rx_link_vc = '0; rx_link_payload = '0; rx_pop = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        check("R10 link_valid", {31'd0, link_valid}, 32'd0);
        check("R10 rx_valid", {29'd0, rx_valid}, 32'd0);
        for (int k = 0; k < 4; k++) begin
            tx_kind = 2'(k);
            #1 check("R10 tx_ready", {31'd0, tx_ready}, 32'd1);
        end

        // R1 / R7: table walk, one flit at a time, credit returned after each
        for (int i = 0; i < 6; i++) begin
            send(VEC[i][19:18], VEC[i][15:0]);
            expect_flit("R1 R7 table", VEC[i][17:16], VEC[i][15:0]);
            @(negedge clk);
            check("R7 single cycle", {31'd0, link_valid}, 32'd0);
            give(3'b001 << VEC[i][17:16]);
        end

        // R5: use up both credits on every lane
        for (int i = 0; i < 2; i++) begin
            send(2'd0, 16'h2000 + 16'(i)); expect_flit("R5 spend lane0", 2'd0, 16'h2000 + 16'(i));
            send(2'd2, 16'h2100 + 16'(i)); expect_flit("R5 spend lane1", 2'd1, 16'h2100 + 16'(i));
            send(2'd3, 16'h2200 + 16'(i)); expect_flit("R5 spend lane2", 2'd2, 16'h2200 + 16'(i));
        end
        send(2'd0, 16'h3000);
        send(2'd1, 16'h3001);
        send(2'd3, 16'h3002);
        @(negedge clk);
        check("R5 stall at zero credit", {31'd0, link_valid}, 32'd0);

        // R3: all lanes released in the same cycle
        give(3'b111);
        expect_flit("R3 first lane2", 2'd2, 16'h3002);
        expect_flit("R3 then lane1", 2'd1, 16'h3001);
        expect_flit("R3 last lane0", 2'd0, 16'h3000);

        // R4: blocked lane2 does not hold up lane0
        send(2'd3, 16'h4003);
        send(2'd0, 16'h4000);
        @(negedge clk);
        check("R4 nothing without credit", {31'd0, link_valid}, 32'd0);
        give(3'b001);
        expect_flit("R4 lane0 passes blocked lane2", 2'd0, 16'h4000);
        give(3'b100);
        expect_flit("R4 lane2 after return", 2'd2, 16'h4003);

        // R2: fill lane1 (no credit), other kinds still accepted
        send(2'd1, 16'h5000);
        send(2'd2, 16'h5001);
        send(2'd1, 16'h5002);
        send(2'd2, 16'h5003);
        tx_kind = 2'd1;
        #1 check("R2 kind1 blocked on full lane1", {31'd0, tx_ready}, 32'd0);
        tx_kind = 2'd2;
        #1 check("R2 kind2 blocked on full lane1", {31'd0, tx_ready}, 32'd0);
        tx_kind = 2'd0;
        #1 check("R2 kind0 open", {31'd0, tx_ready}, 32'd1);
        tx_kind = 2'd3;
        #1 check("R2 kind3 open", {31'd0, tx_ready}, 32'd1);
        send(2'd0, 16'h5100);
        give(3'b001);
        expect_flit("R2 R4 lane0 with lane1 full", 2'd0, 16'h5100);

        // R6: lane1 drains in acceptance order
        for (int i = 0; i < 4; i++) begin
            give(3'b010);
            expect_flit("R6 lane1 order", 2'd1, 16'h5000 + 16'(i));
        end
        tx_kind = 2'd1;
        #1 check("R2 kind1 ready after drain", {31'd0, tx_ready}, 32'd1);

        // R8 / R9: receive steering
        @(negedge clk);
        rx_link_valid = 1'b1;
        rx_link_vc = 2'd1; rx_link_payload = 16'h6001;
        @(negedge clk); rx_link_vc = 2'd1; rx_link_payload = 16'h6002;
        @(negedge clk); rx_link_vc = 2'd2; rx_link_payload = 16'h6003;
        @(negedge clk); rx_link_vc = 2'd0; rx_link_payload = 16'h6004;
        @(negedge clk); rx_link_vc = 2'd3; rx_link_payload = 16'h6005;
        @(negedge clk); rx_link_valid = 1'b0;
        check("R8 rx_valid lanes", {29'd0, rx_valid}, 32'd7);
        check("R8 lane0 head", {16'd0, rx_data[0*W +: W]}, 32'h6004);
        check("R8 lane1 head", {16'd0, rx_data[1*W +: W]}, 32'h6001);
        check("R8 lane2 head", {16'd0, rx_data[2*W +: W]}, 32'h6003);
        rx_pop = 3'b010;
        @(negedge clk); rx_pop = 3'b000;
        check("R8 lane1 second", {16'd0, rx_data[1*W +: W]}, 32'h6002);
        rx_pop = 3'b111;
        @(negedge clk); rx_pop = 3'b000;
        check("R9 tag3 dropped, all empty", {29'd0, rx_valid}, 32'd0);

        done = 1;
        finish_run();
    end
endmodule